// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block sits between the trigger and channel input conditioning of a timer and its counter. It watches an already-selected trigger level and two filtered channel levels. It turns them into per-cycle controls for the counter: a count tick, a count direction, a counter reinitialise pulse that also asks for a register update, a pulse that asks the enable bit to be set, and a pulse that sets the trigger flag.

A four-bit mode input selects the behaviour. Three quadrature encoder variants derive tick and direction from the channel inputs. Five trigger-driven behaviours are available: reset, gated, start-on-trigger, external clock, and combined reset-and-start. They use the trigger input to reinitialise, start, gate or clock the counter. When the controller is disabled, the counter simply advances on every cycle in which software has enabled it.

Every asynchronous input passes through two flip-flop stages before edge detection, and every output is registered. A level change on the trigger or channel inputs therefore reaches the outputs on the third rising clock edge after it. Software enable, mode and the software trigger strobe are synchronous and take effect on the next edge.

Top module: `tmr_slave_ctl`

## Requirements
- R1: While reset is asserted and immediately after it, all five outputs are low.
- R2: A trigger or channel level change applied before clock edge k produces its effect on the outputs after edge k+2, and every edge-derived output pulse lasts exactly one cycle.
- R3: With mode 0 (disabled) or any reserved mode value 9 to 15, tick equals the enable input of the previous cycle, and reinit and start stay low.
- R4: Mode 1 ticks on each edge of channel A. The direction is up (down output 0) when A differs from B after the edge, and down when they are equal.
- R5: Mode 2 ticks on each edge of channel B. The direction is down when A differs from B after the edge, and up when they are equal.
- R6: Mode 3 ticks on an edge of exactly one channel and uses the rule of R4 or R5 for that channel. When both channels change in the same cycle, there is no tick and the direction is kept.
- R7: In encoder, gated and external clock modes no tick is produced while the enable input is low.
- R8: Mode 4 (reset) pulses reinit on a rising trigger edge and ticks whenever enabled.
- R9: Mode 5 (gated) ticks only while enabled and the synchronised trigger is high.
- R10: Mode 6 (start on trigger) pulses start on a rising trigger edge, never pulses reinit, and ticks whenever enabled.
- R11: Mode 7 (external clock) produces one tick per rising trigger edge while enabled.
- R12: Mode 8 (reset and start) pulses both reinit and start on a rising trigger edge and ticks whenever enabled.
- R13: The flag output pulses one cycle after the software strobe in any mode. It also pulses on a rising trigger edge in modes 1 to 4 and 6 to 8, and on both trigger edges in mode 5.
- R14: The down output is 0 in every non-encoder mode. In modes 1 to 3 it holds the direction of the most recent qualifying edge, updated even while the enable input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Selected trigger level (asynchronous) |
| chan_a_i | input | 1 | Filtered channel A level (asynchronous) |
| chan_b_i | input | 1 | Filtered channel B level (asynchronous) |
| run_en_i | input | 1 | Counter enable bit from software |
| mode_i | input | 4 | Behaviour select: 0 off, 1-3 encoder, 4 reset, 5 gated, 6 start, 7 external clock, 8 reset+start |
| sw_trig_i | input | 1 | Software trigger strobe |
| tick_o | output | 1 | Counter advance for this cycle |
| down_o | output | 1 | Count direction, 1 = down |
| reinit_o | output | 1 | Reinitialise counter and request register update |
| start_o | output | 1 | Request to set the enable bit |
| flag_o | output | 1 | Trigger flag set pulse |

## Verification
A stale edge-detect register would show up as a missing or doubled tick, reinit or flag pulse in the third cycle after an input edge. A corrupted encoder direction register would show up on the down output at the next qualifying channel edge. The bench replays every input through a timing model with history queues and compares all five outputs on every cycle, so any such fault is reported within a cycle of becoming visible. Directed sequences cover quadrature rotation in both directions, simultaneous channel changes, gating with the enable input low, and reserved mode values.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        SLV_OFF     = 4'd0,
        SLV_ENC_A   = 4'd1,
        SLV_ENC_B   = 4'd2,
        SLV_ENC_AB  = 4'd3,
        SLV_RESET   = 4'd4,
        SLV_GATED   = 4'd5,
        SLV_START   = 4'd6,
        SLV_EXTCLK  = 4'd7,
        SLV_RST_STA = 4'd8
    } slv_mode_e;

    typedef struct packed {
        logic tick;
        logic down;
        logic reinit;
        logic start;
        logic flag;
    } slv_ctl_t;

endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tsc_edge.sv
module tsc_edge #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign rise_o[g] =  lvl_i[g] & ~prev_q[g];
        assign fall_o[g] = ~lvl_i[g] &  prev_q[g];
    end
endmodule

// File: rtl/tsc_quad.sv
module tsc_quad
    import tmr_slave_pkg::*;
(
    input  slv_mode_e mode_i,
    input  logic      a_i,
    input  logic      b_i,
    input  logic      a_edge_i,
    input  logic      b_edge_i,
    output logic      step_o,
    output logic      down_o
);
    logic a_dn, b_dn;

    assign a_dn = (a_i == b_i);
    assign b_dn = (a_i != b_i);

    always_comb begin
        step_o = 1'b0;
        down_o = 1'b0;
        unique case (mode_i)
            SLV_ENC_A: begin
                step_o = a_edge_i;
                down_o = a_dn;
            end
            SLV_ENC_B: begin
                step_o = b_edge_i;
                down_o = b_dn;
            end
            SLV_ENC_AB: begin
                step_o = a_edge_i ^ b_edge_i;
                down_o = a_edge_i ? a_dn : b_dn;
            end
            default: begin
                step_o = 1'b0;
                down_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
    import tmr_slave_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              chan_a_i,
    input  logic              chan_b_i,
    input  logic              run_en_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              sw_trig_i,
    output logic              tick_o,
    output logic              down_o,
    output logic              reinit_o,
    output logic              start_o,
    output logic              flag_o
);
    localparam int NSIG  = 3;
    localparam int IDX_T = 0;
    localparam int IDX_A = 1;
    localparam int IDX_B = 2;

    logic [NSIG-1:0] lvl, rise, fall;
    slv_mode_e       mode;
    logic            q_step, q_down;
    logic            enc_mode, trig_mode;
    slv_ctl_t        ctl_d, ctl_q;

    assign mode = slv_mode_e'(mode_i);

    tsc_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({chan_b_i, chan_a_i, trig_i}),
        .q_o   (lvl)
    );

    tsc_edge #(.WIDTH(NSIG)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    tsc_quad u_quad (
        .mode_i   (mode),
        .a_i      (lvl[IDX_A]),
        .b_i      (lvl[IDX_B]),
        .a_edge_i (rise[IDX_A] | fall[IDX_A]),
        .b_edge_i (rise[IDX_B] | fall[IDX_B]),
        .step_o   (q_step),
        .down_o   (q_down)
    );

    assign enc_mode  = (mode == SLV_ENC_A) || (mode == SLV_ENC_B) || (mode == SLV_ENC_AB);
    assign trig_mode = (mode_i >= 4'd1) && (mode_i <= 4'd8);

    always_comb begin
        ctl_d        = '0;
        ctl_d.reinit = rise[IDX_T] && ((mode == SLV_RESET) || (mode == SLV_RST_STA));
        ctl_d.start  = rise[IDX_T] && ((mode == SLV_START) || (mode == SLV_RST_STA));
        ctl_d.down   = enc_mode ? (q_step ? q_down : ctl_q.down) : 1'b0;

        case (mode)
            SLV_ENC_A, SLV_ENC_B, SLV_ENC_AB: ctl_d.tick = run_en_i & q_step;
            SLV_GATED:                        ctl_d.tick = run_en_i & lvl[IDX_T];
            SLV_EXTCLK:                       ctl_d.tick = run_en_i & rise[IDX_T];
            default:                          ctl_d.tick = run_en_i;
        endcase

        if (mode == SLV_GATED)
            ctl_d.flag = sw_trig_i | rise[IDX_T] | fall[IDX_T];
        else
            ctl_d.flag = sw_trig_i | (trig_mode & rise[IDX_T]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign tick_o   = ctl_q.tick;
    assign down_o   = ctl_q.down;
    assign reinit_o = ctl_q.reinit;
    assign start_o  = ctl_q.start;
    assign flag_o   = ctl_q.flag;
endmodule

// File: rtl/tmr_slave_ctl_chk.sv
module tmr_slave_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] mode_i,
    input logic       run_en_i,
    input logic       sw_trig_i,
    input logic       tick_o,
    input logic       down_o,
    input logic       reinit_o,
    input logic       start_o,
    input logic       flag_o
);
    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_tick_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && tick_o) |-> $past(run_en_i));

    assert_reinit_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && reinit_o) |-> ($past(mode_i) == 4'd4 || $past(mode_i) == 4'd8));

    assert_start_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && start_o) |-> ($past(mode_i) == 4'd6 || $past(mode_i) == 4'd8));

    assert_reinit_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_o |=> !reinit_o);

    assert_sw_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(sw_trig_i)) |-> flag_o);

    assert_down_encoder_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && down_o) |-> ($past(mode_i) >= 4'd1 && $past(mode_i) <= 4'd3));

    always @(posedge clk) begin
        if (!rst_n) assert_reset_quiet_R1: assert (!tick_o && !down_o && !reinit_o && !start_o && !flag_o);
    end
endmodule

bind tmr_slave_ctl tmr_slave_ctl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .run_en_i  (run_en_i),
    .sw_trig_i (sw_trig_i),
    .tick_o    (tick_o),
    .down_o    (down_o),
    .reinit_o  (reinit_o),
    .start_o   (start_o),
    .flag_o    (flag_o)
);

// File: tb/tmr_slave_ctl_tb_top.sv
module tmr_slave_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0, ca = 1'b0, cb = 1'b0, en = 1'b0, sw = 1'b0;
    logic [3:0] mode = 4'd0;
    logic       tick, down, reinit, start, flag;

    int tests = 0;
    int fails = 0;
    bit comparing = 1'b0;

    always #5 clk = ~clk;

    tmr_slave_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .chan_a_i(ca), .chan_b_i(cb),
        .run_en_i(en), .mode_i(mode), .sw_trig_i(sw),
        .tick_o(tick), .down_o(down), .reinit_o(reinit), .start_o(start), .flag_o(flag)
    );

    // behavioural reference: history queues of sampled inputs, newest first
    bit th[$], ah[$], bh[$];
    bit e_tick, e_down, e_reinit, e_start, e_flag, m_dir;
    int e_mode;

    task automatic clear_hist();
        th = '{0, 0, 0}; ah = '{0, 0, 0}; bh = '{0, 0, 0};
    endtask

    initial clear_hist();

    always @(posedge clk) begin
        if (!rst_n) begin
            clear_hist();
            {e_tick, e_down, e_reinit, e_start, e_flag, m_dir} = '0;
        end else begin
            bit tr, tf, ae, be, st, dn;
            int md;
            md = int'(mode);
            tr = th[1] && !th[2];
            tf = !th[1] && th[2];
            ae = ah[1] != ah[2];
            be = bh[1] != bh[2];
            st = 0; dn = 0;
            if (md == 1 && ae) begin st = 1; dn = !((ah[1] && !bh[1]) || (!ah[1] && bh[1])); end
            if (md == 2 && be) begin st = 1; dn = (bh[1] && !ah[1]) || (!bh[1] && ah[1]); end
            if (md == 3 && (ae ^ be)) begin
                st = 1;
                if (ae) dn = !((ah[1] && !bh[1]) || (!ah[1] && bh[1]));
                else    dn = (bh[1] && !ah[1]) || (!bh[1] && ah[1]);
            end
            if (md >= 1 && md <= 3) begin if (st) m_dir = dn; end
            else m_dir = 0;
            e_down = m_dir;
            case (md)
                1, 2, 3: e_tick = en && st;
                5:       e_tick = en && th[1];
                7:       e_tick = en && tr;
                default: e_tick = en;
            endcase
            e_reinit = tr && (md == 4 || md == 8);
            e_start  = tr && (md == 6 || md == 8);
            e_flag   = sw || (md == 5 ? (tr || tf) : (md >= 1 && md <= 8 && tr));
            e_mode   = md;
            th.push_front(trig); void'(th.pop_back());
            ah.push_front(ca);   void'(ah.pop_back());
            bh.push_front(cb);   void'(bh.pop_back());
        end
    end

    function automatic string tick_req(int md);
        case (md)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R8";
            5: return "R9";
            6: return "R10";
            7: return "R11";
            8: return "R12";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(string req, string nm, bit act, bit exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %0b expected %0b at %0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (comparing && rst_n) begin
            chk(tick_req(e_mode), "tick", tick, e_tick);
            chk("R14", "down", down, e_down);
            chk((e_mode == 8) ? "R12" : "R8", "reinit", reinit, e_reinit);
            chk((e_mode == 8) ? "R12" : "R10", "start", start, e_start);
            chk("R13", "flag", flag, e_flag);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quad(int steps, bit fwd);
        int p;
        p = {ca, cb} == 2'b00 ? 0 : {ca, cb} == 2'b10 ? 1 : {ca, cb} == 2'b11 ? 2 : 3;
        for (int i = 0; i < steps; i++) begin
            p = fwd ? (p + 1) % 4 : (p + 3) % 4;
            case (p)
                0: {ca, cb} = 2'b00;
                1: {ca, cb} = 2'b10;
                2: {ca, cb} = 2'b11;
                default: {ca, cb} = 2'b01;
            endcase
            cyc(3);
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cyc(5);
        // R1: outputs quiet in and after reset
        chk("R1", "all", tick | down | reinit | start | flag, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", "all", tick | down | reinit | start | flag, 1'b0);
        comparing = 1'b1;

        // R2: trigger rise reaches tick after the third edge, one cycle wide
        mode = 4'd7; en = 1'b1; cyc(5);
        trig = 1'b1;
        cyc(1); chk("R2", "tick e1", tick, 1'b0);
        cyc(1); chk("R2", "tick e2", tick, 1'b0);
        cyc(1); chk("R2", "tick e3", tick, 1'b1);
        cyc(1); chk("R2", "tick e4", tick, 1'b0);
        trig = 1'b0; cyc(4);

        // R7: encoder edges with enable low give no tick
        mode = 4'd1; en = 1'b0;
        for (int i = 0; i < 6; i++) begin
            ca = ~ca;
            for (int k = 0; k < 3; k++) begin cyc(1); chk("R7", "tick", tick, 1'b0); end
        end
        mode = 4'd5; trig = 1'b1;
        for (int k = 0; k < 6; k++) begin cyc(1); chk("R7", "gated tick", tick, 1'b0); end
        trig = 1'b0; cyc(4);

        for (int m = 0; m < 11; m++) begin
            mode = 4'(m); en = 1'b1; sw = 1'b0; cyc(4);
            quad(12, 1'b1);
            quad(12, 1'b0);
            {ca, cb} = 2'b11; cyc(4);   // simultaneous change (R6)
            {ca, cb} = 2'b00; cyc(4);
            for (int j = 0; j < 4; j++) begin
                trig = 1'b1; cyc(4); trig = 1'b0; cyc(3);
            end
            sw = 1'b1; cyc(1); sw = 1'b0; cyc(2);
            for (int j = 0; j < 80; j++) begin
                trig = 1'($urandom_range(0, 1));
                ca   = 1'($urandom_range(0, 1));
                cb   = 1'($urandom_range(0, 1));
                en   = ($urandom_range(0, 3) != 0);
                sw   = ($urandom_range(0, 7) == 0);
                cyc(1);
            end
            sw = 1'b0; trig = 1'b0; cyc(4);
        end

        comparing = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule